// File: doc/BRIEF.md
# Up-Down PWM Generator with Event Action Qualifier

This block produces two pulse-width-modulated outputs, A and B, from one symmetric time base. A counter climbs from zero to a programmable period and then descends back to zero, over and over. Four points in that sweep are reported as event flags: the counter at zero, the counter at the period value, the counter matching compare A while rising, and the counter matching compare B while falling. Each output has its own table that says what each of the four events does to it: nothing, drive low, drive high or toggle.

A software force can hold either pin low or high, or hand it back to the action logic. The pin does not change when the force is written. It changes when the force is taken up at a selectable reload point: counter zero, counter period, either of them, or the very next clock. A sync strobe reloads the counter from a phase register and sets the direction it counts afterwards. This lets several instances be lined up. Because events fire only on exact equality, a sync that jumps the counter past a compare point skips that event for the current sweep.

Top module: `pwm_updown_aq`

## Requirements
- R1: While `en` is high the counter steps by one each clock from 0 up to the period register (address 0, written value takes effect at once) and back down to 0, repeating; `evt_zero` is high in each clock the counter is 0 and `evt_prd` in each clock it equals the period.
- R2: Each output has an action byte (address 4 for A, 5 for B) with a 2-bit code per event at bits [1:0] zero, [3:2] period, [5:4] compare A rising, [7:6] compare B falling; code 0 leaves the output alone, 1 drives it low, 2 drives it high, 3 toggles it, the pin changing on the clock after the event.
- R3: `evt_cmpa` fires only when the counter equals compare A exactly while rising, and `evt_cmpb` only at an exact match with compare B while falling; at 0 the counter counts as rising and at the period as falling.
- R4: Compare values (address 2 for A, 3 for B) are written to a shadow and take effect at the next counter zero, already in that clock, so a compare value of 0 fires together with `evt_zero`.
- R5: The control register (address 6) holds a force code per output, bits [1:0] for A and [3:2] for B: 1 holds the pin low, 2 holds it high, 3 releases it, 0 leaves the current force as it is.
- R6: Control bits [5:4] choose when a written force is taken up: 0 at counter zero, 1 at counter period, 2 at either, 3 on the next clock.
- R7: While a pin is forced its action state keeps being updated by events, and on release the pin shows that state at once.
- R8: A `sync_in` pulse with `en` high loads the phase register (address 1) into the counter on the next clock, with control bit 6 giving the direction afterwards (1 up, 0 down); an event whose value the jump skips does not fire in that sweep.
- R9: When events coincide, the force wins over all actions, and a zero or period action wins over a compare action.
- R10: After reset both pins are low, all event flags are low, the counter is 0 and no force is applied.
- R11: With `en` low the counter holds its value and no event flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Phase load strobe |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| evt_zero | output | 1 | Counter at zero |
| evt_prd | output | 1 | Counter at period |
| evt_cmpa | output | 1 | Compare A match while rising |
| evt_cmpb | output | 1 | Compare B match while falling |

## Verification
The counter itself is not visible at the ports. A wrong count value or direction therefore shows up as an event flag that is missing, arrives early or arrives late, and the bench catches it within one sweep. A wrong direction bit shows in the first clock after a period or zero turn-around, because the next compare flag then appears on the wrong slope. A wrong action or force state appears on a pin one clock after the event that should have set it, and it stays wrong until the next event that writes the same output. The bench therefore samples the pins right after each event that is expected to change them.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_TOG = 2'd3} act_e;
  typedef enum logic [1:0] {FRC_KEEP = 2'd0, FRC_LOW = 2'd1, FRC_HIGH = 2'd2, FRC_OFF = 2'd3} force_e;
  typedef enum logic [1:0] {RLD_ZERO = 2'd0, RLD_PRD = 2'd1, RLD_BOTH = 2'd2, RLD_NOW = 2'd3} rld_e;

  // MSB first: compare B falling [7:6], compare A rising [5:4], period [3:2], zero [1:0]
  typedef struct packed {
    act_e cmpb_dn;
    act_e cmpa_up;
    act_e prd;
    act_e zero;
  } act_cfg_t;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpa;
    logic cmpb;
  } evt_t;

  localparam int RA_PRD  = 0;
  localparam int RA_PHS  = 1;
  localparam int RA_CMPA = 2;
  localparam int RA_ACTA = 4;
  localparam int RA_CTL  = 6;
  localparam int CTL_W   = 7;
  localparam int NCH     = 2;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    at_zero,
  output logic [CW-1:0]           prd,
  output logic [CW-1:0]           phase,
  output logic [NCH-1:0][CW-1:0]  cmp_use,
  output act_cfg_t [NCH-1:0]      act_cfg,
  output force_e [NCH-1:0]        force_req,
  output rld_e                    rld,
  output logic                    sync_dir
);
  logic [CW-1:0]          prd_q, prd_n, phs_q, phs_n;
  logic [NCH-1:0][CW-1:0] csh_q, csh_n, cact_q, cact_n;
  act_cfg_t [NCH-1:0]     act_q, act_n;
  logic [CTL_W-1:0]       ctl_q, ctl_n;

  always_comb begin
    prd_n  = prd_q;
    phs_n  = phs_q;
    csh_n  = csh_q;
    cact_n = cact_q;
    act_n  = act_q;
    ctl_n  = ctl_q;
    if (wr_en && wr_addr == AW'(RA_PRD)) prd_n = wr_data;
    if (wr_en && wr_addr == AW'(RA_PHS)) phs_n = wr_data;
    if (wr_en && wr_addr == AW'(RA_CTL)) ctl_n = wr_data[CTL_W-1:0];
    for (int i = 0; i < NCH; i++) begin
      if (wr_en && wr_addr == AW'(RA_CMPA + i)) csh_n[i] = wr_data;
      if (wr_en && wr_addr == AW'(RA_ACTA + i)) act_n[i] = act_cfg_t'(wr_data[7:0]);
      if (at_zero) cact_n[i] = csh_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q  <= '0;
      phs_q  <= '0;
      csh_q  <= '0;
      cact_q <= '0;
      act_q  <= '0;
      ctl_q  <= '0;
    end else begin
      prd_q  <= prd_n;
      phs_q  <= phs_n;
      csh_q  <= csh_n;
      cact_q <= cact_n;
      act_q  <= act_n;
      ctl_q  <= ctl_n;
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cmp_use[i]   = at_zero ? csh_q[i] : cact_q[i];
      force_req[i] = force_e'(ctl_q[2*i +: 2]);
    end
  end

  assign prd      = prd_q;
  assign phase    = phs_q;
  assign act_cfg  = act_q;
  assign rld      = rld_e'(ctl_q[5:4]);
  assign sync_dir = ctl_q[6];
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   sync_in,
  input  logic                   sync_dir,
  input  logic [CW-1:0]          prd,
  input  logic [CW-1:0]          phase,
  input  logic [NCH-1:0][CW-1:0] cmp_use,
  output evt_t                   evt
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          dir_q, dir_n, up_eff;

  always_comb begin
    if (cnt_q == '0)      up_eff = 1'b1;
    else if (cnt_q >= prd) up_eff = 1'b0;
    else                  up_eff = dir_q;
  end

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    if (en) begin
      if (sync_in) begin
        cnt_n = phase;
        dir_n = sync_dir;
      end else if (prd == '0) begin
        cnt_n = '0;
        dir_n = 1'b1;
      end else begin
        dir_n = up_eff;
        cnt_n = up_eff ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  always_comb begin
    evt.zero = en && (cnt_q == '0);
    evt.prd  = en && (cnt_q == prd);
    evt.cmpa = en && up_eff && (cnt_q == cmp_use[0]);
    evt.cmpb = en && !up_eff && (cnt_q == cmp_use[1]);
  end

  // R1
  turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sync_in && cnt_q == prd && prd != '0) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

  // R8
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sync_in) |=> (cnt_q == $past(phase) && dir_q == $past(sync_dir)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_t     evt,
  input  act_cfg_t cfg,
  input  force_e   force_req,
  input  rld_e     rld,
  output logic     pin
);
  logic   state_q, state_n, load;
  force_e frc_q, frc_n;
  act_e   pick;

  always_comb begin
    case (rld)
      RLD_ZERO: load = evt.zero;
      RLD_PRD:  load = evt.prd;
      RLD_BOTH: load = evt.zero || evt.prd;
      default:  load = 1'b1;
    endcase
    frc_n = (load && force_req != FRC_KEEP) ? force_req : frc_q;
  end

  always_comb begin
    if (evt.zero && cfg.zero != ACT_NONE)         pick = cfg.zero;
    else if (evt.prd && cfg.prd != ACT_NONE)      pick = cfg.prd;
    else if (evt.cmpa && cfg.cmpa_up != ACT_NONE) pick = cfg.cmpa_up;
    else if (evt.cmpb)                            pick = cfg.cmpb_dn;
    else                                          pick = ACT_NONE;
    case (pick)
      ACT_LOW:  state_n = 1'b0;
      ACT_HIGH: state_n = 1'b1;
      ACT_TOG:  state_n = !state_q;
      default:  state_n = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      frc_q   <= FRC_OFF;
    end else begin
      state_q <= state_n;
      frc_q   <= frc_n;
    end
  end

  always_comb begin
    case (frc_q)
      FRC_LOW:  pin = 1'b0;
      FRC_HIGH: pin = 1'b1;
      default:  pin = state_q;
    endcase
  end

  // R2
  zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.zero && cfg.zero == ACT_HIGH) |=> state_q);

  // R9
  prd_over_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.prd && !evt.zero && cfg.prd == ACT_LOW) |=> !state_q);
endmodule

// File: rtl/pwm_updown_aq.sv
module pwm_updown_aq
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          evt_zero,
  output logic          evt_prd,
  output logic          evt_cmpa,
  output logic          evt_cmpb
);
  logic [CW-1:0]          prd, phase;
  logic [NCH-1:0][CW-1:0] cmp_use;
  act_cfg_t [NCH-1:0]     act_cfg;
  force_e [NCH-1:0]       force_req;
  rld_e                   rld;
  logic                   sync_dir;
  evt_t                   evt;
  logic [NCH-1:0]         pins;

  pwm_aq_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .at_zero(evt.zero), .prd(prd), .phase(phase), .cmp_use(cmp_use),
    .act_cfg(act_cfg), .force_req(force_req), .rld(rld), .sync_dir(sync_dir));

  pwm_aq_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in), .sync_dir(sync_dir),
    .prd(prd), .phase(phase), .cmp_use(cmp_use), .evt(evt));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_aq_chan u_ch (
      .clk(clk), .rst_n(rst_n), .evt(evt), .cfg(act_cfg[g]),
      .force_req(force_req[g]), .rld(rld), .pin(pins[g]));
  end

  assign pwm_a    = pins[0];
  assign pwm_b    = pins[1];
  assign evt_zero = evt.zero;
  assign evt_prd  = evt.prd;
  assign evt_cmpa = evt.cmpa;
  assign evt_cmpb = evt.cmpb;

  // R3
  slope_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_cmpa && evt_cmpb));
endmodule

// File: tb/sim_pwm_updown_aq.sv
`timescale 1ns/100ps
module sim_pwm_updown_aq;
  logic clk = 1'b0;
  logic rst_n, en, wr_en, sync_in;
  logic [2:0] wr_addr;
  logic [15:0] wr_data;
  logic pwm_a, pwm_b, evt_zero, evt_prd, evt_cmpa, evt_cmpb;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic a0;

  always #2.5 clk = ~clk;

  pwm_updown_aq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .pwm_a(pwm_a), .pwm_b(pwm_b), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb));

  // {zero, prd, cmpa, cmpb, a, b} per clock; period 4, cmp A 1, cmp B 3
  localparam logic [5:0] VEC [11] = '{
    6'b100000, 6'b001011, 6'b000010, 6'b000010, 6'b010010, 6'b000101,
    6'b000000, 6'b000000, 6'b100000, 6'b001011, 6'b000010};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_evt(input bit use_prd);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (use_prd ? evt_prd : evt_zero) break;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; sync_in = 1'b0; wr_addr = '0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk("R10 pins", {pwm_a, pwm_b}, 2'b00);
    chk("R10 flags", {evt_zero, evt_prd, evt_cmpa, evt_cmpb}, 4'b0000);

    wr(3'd0, 16'd4);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'h0006);
    wr(3'd5, 16'h005A);

    // R1 R2 R3 table of one and a quarter sweeps
    en = 1'b1; #1;
    for (int k = 0; k < 11; k++) begin
      if (k > 0) step(1);
      chk($sformatf("R1/R2/R3 vec%0d", k),
          {evt_zero, evt_prd, evt_cmpa, evt_cmpb, pwm_a, pwm_b}, VEC[k]);
    end
    en = 1'b0;   // frozen at count 2 rising, A=1 B=0
    step(2);
    // R11 frozen: no flags, pins unchanged
    chk("R11 flags idle", {evt_zero, evt_prd, evt_cmpa, evt_cmpb}, 4'b0000);
    chk("R11 pins held", {pwm_a, pwm_b}, 2'b10);

    // R5 R6 immediate force: A low, B high
    wr(3'd6, 16'h0039);
    step(2);
    chk("R5 force A low B high", {pwm_a, pwm_b}, 2'b01);
    // R7 release returns action state
    wr(3'd6, 16'h003F);
    step(2);
    chk("R7 release", {pwm_a, pwm_b}, 2'b10);

    // R6 force B low taken at zero only; A code 0 keeps its release
    wr(3'd6, 16'h0004);
    step(2);
    chk("R6 not yet loaded", pwm_b, 1'b0);
    en = 1'b1;
    step(3);
    chk("R6 before zero B follows action", pwm_b, 1'b1);
    step(3);
    chk("R1 zero reached", evt_zero, 1'b1);
    step(1);
    chk("R6/R9 force at zero beats set", pwm_b, 1'b0);
    chk("R5 keep code on A", pwm_a, 1'b1);
    wr(3'd6, 16'h003C);

    // R8 sync up past compare A
    wr(3'd1, 16'd2);
    wr(3'd6, 16'h0070);
    sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      if (k > 1) step(1);
      chk($sformatf("R8 up cmpa skipped k%0d", k), evt_cmpa, 1'b0);
      if (k == 3) chk("R8 prd after up sync", evt_prd, 1'b1);
      if (k == 7) chk("R8 zero after up sync", evt_zero, 1'b1);
    end

    // R8 sync down; R3 compare A not on falling slope
    wr(3'd6, 16'h0030);
    sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    step(1);
    chk("R3 cmpa not falling", evt_cmpa, 1'b0);
    step(1);
    chk("R8 zero after down sync", evt_zero, 1'b1);

    // R4 compare 0 fires with zero; R9 zero set beats compare clear
    wr(3'd2, 16'd0);
    wait_evt(1'b0);
    chk("R4 cmp zero fires", {evt_zero, evt_cmpa}, 2'b11);
    step(1);
    chk("R9 zero over compare", pwm_b, 1'b1);

    // R11 enable low suppresses flags at zero
    wait_evt(1'b0);
    en = 1'b0; #1;
    chk("R11 zero flag gated", evt_zero, 1'b0);
    step(3);
    en = 1'b1; #1;
    chk("R11 counter held at zero", evt_zero, 1'b1);

    // R2 toggle on zero, no action on period
    wr(3'd4, 16'h0003);
    wait_evt(1'b0);
    step(1);
    a0 = pwm_a;
    wait_evt(1'b1);
    step(1);
    chk("R2 no-action code", pwm_a, a0);
    wait_evt(1'b0);
    step(1);
    chk("R2 toggle", pwm_a, !a0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule